// File: doc/BRIEF.md
# Cascaded DMA Request Mask and Status Unit

This unit sits between the request sources of eight DMA channels and the channel arbiter. The channels form two groups of four. Each group has its own mask register, which blocks or passes its requests, and its own status register, which reports terminal-count events and pending requests. The primary group (channels 0 to 3) reaches the arbiter only through channel 4 of the secondary group. Masking channel 4 therefore silences channels 0 to 3 as well. The gated request of channel 4 is the cascade request, raised whenever any primary channel has an effective request.

A channel's pending request is the OR of its hardware request line and its bit of the software-request vector. Software requests also stand for timed-out block transfers. Terminal-count pulses from the transfer engines are latched in sticky status bits. A status read returns them and then clears them. A pulse that arrives in the same cycle as that read is kept. The register bus uses single-cycle read and write strobes. Read data is combinational and is zero while the read strobe is low.

Register map (byte addresses, parameterised): primary mask 0Fh, primary mask-to-all-ones command 0Dh, primary status 08h, secondary mask DEh, secondary mask-to-all-ones command DAh, secondary status D0h.

Top module: `dma_mask_status`

## Requirements
- R1: While reset is high and after it, both mask registers hold 4'b1111, all terminal-count bits are 0 and eff_req is 0.
- R2: A write to a mask address stores reg_wdata[3:0] at that clock edge. Bit n masks channel n of the group, and 1 blocks it. A read of a mask address returns the mask in bits 3:0 and zero in bits 7:4.
- R3: A write of any data to a group's mask-to-all-ones address sets that group's four mask bits to 1 at that edge.
- R4: For channels 5 to 7, eff_req[n] is registered: it equals (dreq[n] | sw_req[n]) AND NOT mask[n], as sampled at the previous edge.
- R5: For channels 0 to 3, eff_req[n] is registered and is also gated by the channel 4 mask. While mask bit 4 was 1 at the previous edge, eff_req[3:0] is 0.
- R6: eff_req[4] is high exactly when any of eff_req[3:0] is high. dreq[4] and sw_req[4] have no effect on eff_req.
- R7: A tc_pulse[n] sets terminal-count bit n at the next edge. The bit stays set until a status read of its group or a reset.
- R8: A status read returns {pending[3:0] of the group, terminal-count bits[3:0]}. The terminal-count bits of that group clear at the edge that ends the read.
- R9: A tc_pulse that arrives in the same cycle as a status read of its group is set after the clear, so the bit reads 1 afterwards.
- R10: Status bits 7:4 show the live dreq | sw_req of the group's channels, whatever the mask.
- R11: Reads of unmapped addresses return 0, writes to them change no register, and reg_rdata is 0 while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | 8 | Hardware request lines, one per channel |
| sw_req | input | 8 | Software / timed-out block request vector |
| tc_pulse | input | 8 | Terminal-count pulses from the transfer engines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 4 | Write data (implemented mask bits) |
| reg_rdata | output | 8 | Combinational read data |
| eff_req | output | 8 | Registered masked requests to the arbiter |

## Verification
Read data is due in the same cycle as the read strobe. The bench samples reg_rdata one time step after driving the inputs on the falling edge. Mask writes, mask-to-all-ones commands, terminal-count captures and read clears take effect at the next rising edge, so the next vector sees them in its read data. eff_req carries one register stage. It is sampled one time step after the rising edge that ends each vector, and the expected value uses the inputs of that vector and the mask that held before that edge.

// File: rtl/dma_ms_pkg.sv
package dma_ms_pkg;
  localparam int GROUPS = 2;

  // AND a request vector with a mask (1 = block)
  function automatic logic [3:0] gate4(input logic [3:0] req, input logic [3:0] msk);
    return req & ~msk;
  endfunction
endpackage

// File: rtl/dma_grp_mask.sv
module dma_grp_mask #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          set_all,
  input  logic [CH-1:0] wdata,
  output logic [CH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || set_all) mask_q <= '1;
    else if (wr_en)     mask_q <= wdata;
  end
endmodule

// File: rtl/dma_grp_tc.sv
module dma_grp_tc #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_clr,
  input  logic [CH-1:0] tc_in,
  output logic [CH-1:0] tc_q
);
  logic [CH-1:0] kept;
  assign kept = rd_clr ? '0 : tc_q;

  always_ff @(posedge clk) begin
    if (rst) tc_q <= '0;
    else     tc_q <= kept | tc_in;   // new events win over the clear
  end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*CH-1:0] pend,
  input  logic [2*CH-1:0] mask,
  output logic [2*CH-1:0] eff_q
);
  logic [CH-1:0] lo_en;
  logic [CH-1:0] lo_eff;
  logic [CH-2:0] hi_eff;

  assign lo_en  = ~mask[CH-1:0] & {CH{~mask[CH]}};
  assign lo_eff = pend[CH-1:0] & lo_en;
  assign hi_eff = pend[2*CH-1:CH+1] & ~mask[2*CH-1:CH+1];

  always_ff @(posedge clk) begin
    if (rst) eff_q <= '0;
    else     eff_q <= {hi_eff, |lo_eff, lo_eff};
  end
endmodule

// File: rtl/dma_mask_status.sv
module dma_mask_status #(
  parameter int          CH         = 4,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  MASK0_ADDR = 8'h0F,
  parameter logic [7:0]  SET0_ADDR  = 8'h0D,
  parameter logic [7:0]  STAT0_ADDR = 8'h08,
  parameter logic [7:0]  MASK1_ADDR = 8'hDE,
  parameter logic [7:0]  SET1_ADDR  = 8'hDA,
  parameter logic [7:0]  STAT1_ADDR = 8'hD0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*CH-1:0]     dreq,
  input  logic [2*CH-1:0]     sw_req,
  input  logic [2*CH-1:0]     tc_pulse,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [CH-1:0]       reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*CH-1:0]     eff_req
);
  import dma_ms_pkg::*;
  localparam int NCH = GROUPS * CH;
  localparam int PAD = DATA_W - CH;

  logic [NCH-1:0]    pend;
  logic [NCH-1:0]    mask_all;
  logic [NCH-1:0]    tc_all;
  logic [GROUPS-1:0] stat_clr;
  logic [GROUPS-1:0] hit_mask;
  logic [GROUPS-1:0] hit_stat;

  assign pend = dreq | sw_req;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [7:0] A_MASK = (g == 0) ? MASK0_ADDR : MASK1_ADDR;
    localparam logic [7:0] A_SET  = (g == 0) ? SET0_ADDR  : SET1_ADDR;
    localparam logic [7:0] A_STAT = (g == 0) ? STAT0_ADDR : STAT1_ADDR;
    logic wr_m, wr_s;

    assign hit_mask[g] = (reg_addr == ADDR_W'(A_MASK));
    assign hit_stat[g] = (reg_addr == ADDR_W'(A_STAT));
    assign wr_m        = reg_wr && hit_mask[g];
    assign wr_s        = reg_wr && (reg_addr == ADDR_W'(A_SET));
    assign stat_clr[g] = reg_rd && hit_stat[g];

    dma_grp_mask #(.CH(CH)) mask_i (
      .clk(clk), .rst(rst), .wr_en(wr_m), .set_all(wr_s),
      .wdata(reg_wdata), .mask_q(mask_all[g*CH +: CH])
    );

    dma_grp_tc #(.CH(CH)) tc_i (
      .clk(clk), .rst(rst), .rd_clr(stat_clr[g]),
      .tc_in(tc_pulse[g*CH +: CH]), .tc_q(tc_all[g*CH +: CH])
    );
  end

  dma_req_gate #(.CH(CH)) gate_i (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask_all), .eff_q(eff_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (hit_mask[g]) reg_rdata = {{PAD{1'b0}}, mask_all[g*CH +: CH]};
        if (hit_stat[g]) reg_rdata = DATA_W'({pend[g*CH +: CH], tc_all[g*CH +: CH]});
      end
    end
  end
endmodule

// File: rtl/dma_mask_status_chk.sv
module dma_mask_status_chk #(
  parameter int         CH         = 4,
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] MASK0_ADDR = 8'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic [2*CH-1:0]   pend,
  input logic [2*CH-1:0]   mask_all,
  input logic [2*CH-1:0]   tc_all,
  input logic [2*CH-1:0]   tc_pulse,
  input logic [1:0]        stat_clr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [2*CH-1:0]   eff_req
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R4
  hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> eff_req[2*CH-1:CH+1] ==
      ($past(pend[2*CH-1:CH+1]) & ~$past(mask_all[2*CH-1:CH+1])));

  // R5
  cascade_block_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mask_all[CH]) |-> eff_req[CH-1:0] == '0);

  // R6
  cascade_req_chk: assert property (@(posedge clk) disable iff (rst)
    eff_req[CH] == (|eff_req[CH-1:0]));

  // R7
  tc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (tc_all & $past(tc_pulse)) == $past(tc_pulse));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(stat_clr[0]) |-> tc_all[CH-1:0] == $past(tc_pulse[CH-1:0]));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(MASK0_ADDR) |-> reg_rdata[DATA_W-1:CH] == '0);
endmodule

bind dma_mask_status dma_mask_status_chk #(
  .CH(CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK0_ADDR(MASK0_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .pend(pend), .mask_all(mask_all), .tc_all(tc_all),
  .tc_pulse(tc_pulse), .stat_clr(stat_clr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .eff_req(eff_req)
);

// File: tb/dma_mask_status_tb.sv
module dma_mask_status_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dreq = '0, sw_req = '0, tc_pulse = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [7:0] reg_rdata, eff_req;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_mask_status dut_i (
    .clk(clk), .rst(rst), .dreq(dreq), .sw_req(sw_req), .tc_pulse(tc_pulse),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eff_req(eff_req)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] addr;
    logic [3:0] wd;
    logic [7:0] dq;
    logic [7:0] sw;
    logic [7:0] tc;
    logic [7:0] x_rd;
    logic [7:0] x_eff;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b1,8'h0F,4'h0,8'hFF,8'h00,8'h00,8'h0F,8'h00}, // R1 R6 mask reads all ones, dreq4 no effect
    '{1'b1,1'b0,8'h0F,4'h0,8'h0F,8'h00,8'h00,8'h00,8'h00}, // R2 write primary mask 0; R11 rdata 0 w/o rd
    '{1'b0,1'b1,8'h0F,4'h0,8'h0F,8'h00,8'h00,8'h00,8'h00}, // R2 R5 ch4 still masked
    '{1'b1,1'b0,8'hDE,4'hE,8'h0F,8'h00,8'h00,8'h00,8'h00}, // R2 unmask ch4 only
    '{1'b0,1'b0,8'h00,4'h0,8'h0F,8'h00,8'h00,8'h00,8'h1F}, // R4 R6 cascade passes
    '{1'b0,1'b0,8'h00,4'h0,8'hA5,8'h00,8'h00,8'h00,8'h15}, // R4 ch5,7 masked
    '{1'b1,1'b0,8'hDE,4'h1,8'hA5,8'h00,8'h00,8'h00,8'h15}, // R2 mask ch4, open 5-7
    '{1'b0,1'b0,8'h00,4'h0,8'hA5,8'h00,8'h00,8'h00,8'hA0}, // R5 cascade block, R4 hi pass
    '{1'b0,1'b1,8'h08,4'h0,8'h00,8'h02,8'h01,8'h20,8'h00}, // R9 R10 tc with read, sw shows
    '{1'b0,1'b1,8'h08,4'h0,8'h00,8'h00,8'h00,8'h01,8'h00}, // R9 R8 survived clear
    '{1'b0,1'b1,8'h08,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R8 cleared
    '{1'b0,1'b1,8'hD0,4'h0,8'h40,8'h00,8'h80,8'h40,8'h40}, // R10 R9 secondary
    '{1'b0,1'b1,8'hD0,4'h0,8'h00,8'h00,8'h00,8'h08,8'h00}, // R8 secondary tc
    '{1'b0,1'b0,8'h00,4'h0,8'h00,8'h00,8'h02,8'h00,8'h00}, // R7 pulse ch1
    '{1'b0,1'b0,8'h00,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R7 idle
    '{1'b0,1'b1,8'h08,4'h0,8'h00,8'h00,8'h00,8'h02,8'h00}, // R7 sticky
    '{1'b1,1'b0,8'h55,4'hF,8'h00,8'h00,8'h00,8'h00,8'h00}, // R11 unmapped write
    '{1'b0,1'b1,8'h0F,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R11 mask0 unchanged
    '{1'b0,1'b1,8'h55,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R11 unmapped read
    '{1'b1,1'b0,8'h0D,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R3 primary all-ones
    '{1'b0,1'b1,8'h0F,4'h0,8'h0F,8'h00,8'h00,8'h0F,8'h00}, // R3 readback
    '{1'b1,1'b0,8'hDA,4'h0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R3 secondary all-ones
    '{1'b0,1'b1,8'hDE,4'h0,8'hE0,8'h00,8'h00,8'h0F,8'h00}  // R3 readback, R4 blocked
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string tag);
    @(negedge clk);
    reg_wr = v.wr; reg_rd = v.rd; reg_addr = v.addr; reg_wdata = v.wd;
    dreq = v.dq; sw_req = v.sw; tc_pulse = v.tc;
    #1 check({tag, " rdata"}, reg_rdata, v.x_rd);
    @(posedge clk);
    #1 check({tag, " eff_req"}, eff_req, v.x_eff);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    apply('{1'b0,1'b1,a,4'h0,8'h00,8'h00,8'h00,exp,8'h00}, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 eff in reset", eff_req, 8'h00);
    @(negedge clk) rst = 1'b0;
    rd_chk(8'h0F, 8'h0F, "R1 mask0");
    rd_chk(8'hDE, 8'h0F, "R1 mask1");
    rd_chk(8'h08, 8'h00, "R1 stat0");
    rd_chk(8'hD0, 8'h00, "R1 stat1");
    for (int i = 0; i < NV; i++) apply(VT[i], $sformatf("vec%0d", i));

    // R2 R4: open every channel, then reset mid-run with pending tc
    apply('{1'b1,1'b0,8'h0F,4'h0,8'h00,8'h00,8'h0C,8'h00,8'h00}, "R2 open0");
    apply('{1'b1,1'b0,8'hDE,4'h0,8'hFF,8'h00,8'h00,8'h00,8'h00}, "R2 open1");
    apply('{1'b0,1'b0,8'h00,4'h0,8'hEF,8'h00,8'h00,8'h00,8'hFF}, "R4 R6 all open");
    @(negedge clk) begin rst = 1'b1; dreq = '0; reg_wr = 1'b0; reg_rd = 1'b0; tc_pulse = '0; end
    @(posedge clk); #1 check("R1 eff after reset", eff_req, 8'h00);
    @(negedge clk) rst = 1'b0;
    rd_chk(8'h08, 8'h00, "R1 tc cleared by reset");
    rd_chk(8'hDE, 8'h0F, "R1 mask1 reset");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule